// File: doc/BRIEF.md
# Tone Transceiver Host Register Interface

This block connects a host processor to the core of a tone transceiver through a narrow 4-bit parallel bus. The bus has a chip select that comes from the host's own address decode, one register-select line, and separate read and write strobes. Every access completes in the clock cycle in which its strobe is seen, so the host never waits. Through this bus the host reaches five registers: a read-only receive data register, a write-only transmit data register, two control registers, and a read-only status register.

The two control registers, A and B, answer at the same address. Control A is the default target of a control write. When the host writes control A with its top bit (b3) set, a one-shot redirect is armed. The next control write then lands in control B and clears the redirect, so the write after it goes back to control A. Toward the core, the block drives the two control words and the transmit tone code, and gives a one-cycle load pulse for each new transmit code. From the core it takes each newly decoded digit and the live status flags.

Top module: `tone_host_regs`

## Requirements
- R1: While reset is high, and in the cycle after it falls, ctl_a, ctl_b, tx_code, bus_rdata and tx_load are all zero. The receive data register, the pending flag and the redirect flag are also clear.
- R2: A write with bus_cs=1 and bus_rs=0 loads bus_wdata into tx_code at that clock edge. tx_load is 1 for exactly the one cycle after that edge.
- R3: A write with bus_cs=1 and bus_rs=1, while no redirect is armed, loads bus_wdata into ctl_a. The redirect becomes armed exactly when bit 3 of the written value is 1.
- R4: While the redirect is armed, the next write with bus_cs=1 and bus_rs=1 loads ctl_b and leaves ctl_a unchanged. It also disarms the redirect, so the write after it goes to ctl_a.
- R5: A control A write with bit 3 equal to 0 leaves the redirect disarmed, so the following control write also goes to ctl_a.
- R6: A write to transmit data (bus_rs=0) neither arms nor disarms the redirect.
- R7: A cycle with core_rx_valid=1 captures core_rx_code into the receive data register. A read with bus_cs=1 and bus_rs=0 places that register on bus_rdata one cycle after the strobe edge.
- R8: A read with bus_cs=1 and bus_rs=1 returns status on bus_rdata one cycle after the strobe edge. Bit 0 is the pending-digit flag, and bits 3:1 are core_flags[2:0] as sampled at that edge.
- R9: The pending flag is set by core_rx_valid and is cleared by a receive data read. When both occur in the same cycle, the flag stays set.
- R10: Strobes with bus_cs=0 have no effect. ctl_a, ctl_b, tx_code, bus_rdata and the redirect state do not change, and tx_load stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Chip select from external address decode, active high |
| bus_rs | input | 1 | Register select: 0 data, 1 control/status |
| bus_rd | input | 1 | Read strobe, one cycle, active high |
| bus_wr | input | 1 | Write strobe, one cycle, active high |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Registered read data, holds between reads |
| ctl_a | output | 4 | Control A word to the core |
| ctl_b | output | 4 | Control B word to the core |
| tx_code | output | 4 | Transmit tone pair code |
| tx_load | output | 1 | One-cycle pulse after a transmit code write |
| core_rx_code | input | 4 | Digit code decoded by the core |
| core_rx_valid | input | 1 | New digit strobe from the core |
| core_flags | input | 3 | Live status flags from the core |

## Verification
The redirect steering gets several patterns. Control A writes with bit 3 set are followed directly by control writes. Armed states are separated by transmit writes and by deselected strobes. Control A writes with bit 3 clear are written back to back. These patterns tell a correct one-shot redirect apart from one that never disarms, one that is disturbed by data-side writes, or one that ignores chip select. Reads of receive data are placed against digit strobes, sometimes in the same cycle, so the set-over-clear rule for the pending flag can be seen. Seeded random sequences mix all access kinds and are checked against a bench model after every access.

// File: rtl/tone_regs_pkg.sv
package tone_regs_pkg;

  localparam int unsigned TRX_DW = 4;

  typedef struct packed {
    logic wr_data;
    logic wr_ctl;
    logic rd_data;
    logic rd_stat;
  } acc_t;

endpackage

// File: rtl/tone_bus_decode.sv
module tone_bus_decode
  import tone_regs_pkg::*;
(
  input  logic cs,
  input  logic rs,
  input  logic rd,
  input  logic wr,
  output acc_t acc
);

  always_comb begin
    acc.wr_data = cs & wr & ~rs;
    acc.wr_ctl  = cs & wr &  rs;
    acc.rd_data = cs & rd & ~rs;
    acc.rd_stat = cs & rd &  rs;
  end

endmodule

// File: rtl/tone_ctl_steer.sv
module tone_ctl_steer #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctl,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_a,
  output logic [DW-1:0] ctl_b,
  output logic          armed
);

  localparam int unsigned MSB = DW - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_a <= '0;
      ctl_b <= '0;
      armed <= 1'b0;
    end else if (wr_ctl) begin
      if (armed) begin
        ctl_b <= wdata;
        armed <= 1'b0;
      end else begin
        ctl_a <= wdata;
        armed <= wdata[MSB];
      end
    end
  end

  // R4
  redirect_one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && armed) |=> (!armed && $stable(ctl_a)));

  // R3
  ctl_a_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && !armed) |=> (ctl_a == $past(wdata) && $stable(ctl_b)));

  // R10
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ctl |=> ($stable(ctl_a) && $stable(ctl_b) && $stable(armed)));

endmodule

// File: rtl/tone_rx_capture.sv
module tone_rx_capture #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_code,
  input  logic          rd_data,
  output logic [DW-1:0] rx_q,
  output logic          pend
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= '0;
      pend <= 1'b0;
    end else begin
      if (rx_valid) rx_q <= rx_code;
      if (rx_valid)     pend <= 1'b1;
      else if (rd_data) pend <= 1'b0;
    end
  end

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !rx_valid) |=> !pend);

  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> (pend && rx_q == $past(rx_code)));

endmodule

// File: rtl/tone_host_regs.sv
module tone_host_regs
  import tone_regs_pkg::*;
#(
  parameter int unsigned DW = TRX_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cs,
  input  logic          bus_rs,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] ctl_a,
  output logic [DW-1:0] ctl_b,
  output logic [DW-1:0] tx_code,
  output logic          tx_load,
  input  logic [DW-1:0] core_rx_code,
  input  logic          core_rx_valid,
  input  logic [DW-2:0] core_flags
);

  localparam int unsigned FW = DW - 1;

  acc_t          acc;
  logic          armed;
  logic [DW-1:0] rx_q;
  logic          pend;
  logic [DW-1:0] stat_w;

  tone_bus_decode u_dec (
    .cs  (bus_cs),
    .rs  (bus_rs),
    .rd  (bus_rd),
    .wr  (bus_wr),
    .acc (acc)
  );

  tone_ctl_steer #(.DW(DW)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .wr_ctl (acc.wr_ctl),
    .wdata  (bus_wdata),
    .ctl_a  (ctl_a),
    .ctl_b  (ctl_b),
    .armed  (armed)
  );

  tone_rx_capture #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (core_rx_valid),
    .rx_code  (core_rx_code),
    .rd_data  (acc.rd_data),
    .rx_q     (rx_q),
    .pend     (pend)
  );

  // status word: pending flag at bit 0, core flags above it
  assign stat_w = {core_flags[FW-1:0], pend};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_code <= '0;
      tx_load <= 1'b0;
    end else begin
      tx_load <= acc.wr_data;
      if (acc.wr_data) tx_code <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              bus_rdata <= '0;
    else if (acc.rd_data) bus_rdata <= rx_q;
    else if (acc.rd_stat) bus_rdata <= stat_w;
  end

  // R2
  tx_load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> $past(bus_cs && bus_wr && !bus_rs));

  // R10
  deselect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_cs |=> ($stable(bus_rdata) && $stable(tx_code) && !tx_load));

  // R6
  data_write_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cs && bus_wr && !bus_rs) |=> $stable(armed));

endmodule

// File: tb/tone_host_regs_tb.sv
module tone_host_regs_tb_top;

  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_cs, bus_rs, bus_rd, bus_wr;
  logic [DW-1:0] bus_wdata, bus_rdata, ctl_a, ctl_b, tx_code;
  logic          tx_load;
  logic [DW-1:0] core_rx_code;
  logic          core_rx_valid;
  logic [DW-2:0] core_flags;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_a, m_b, m_tx, m_rx, m_rd;
  logic          m_arm, m_pend;

  always #5 clk = ~clk;

  tone_host_regs #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_rs(bus_rs), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctl_a(ctl_a), .ctl_b(ctl_b), .tx_code(tx_code), .tx_load(tx_load),
    .core_rx_code(core_rx_code), .core_rx_valid(core_rx_valid),
    .core_flags(core_flags)
  );

  function automatic logic [DW-1:0] exp_status(logic [DW-2:0] f, logic p);
    return {f, p};
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req, logic load_exp);
    chk({req, " ctl_a"}, ctl_a, m_a);
    chk({req, " ctl_b"}, ctl_b, m_b);
    chk({req, " tx_code"}, tx_code, m_tx);
    chk({req, " rdata"}, bus_rdata, m_rd);
    chk({req, " tx_load"}, {3'b0, tx_load}, {3'b0, load_exp});
  endtask

  // one bus cycle: strobes driven at a falling edge, results sampled at the next one
  task automatic access(logic cs, logic rs, logic rd, logic wr, logic [DW-1:0] d,
                        logic rxv, logic [DW-1:0] rxc, logic [DW-2:0] fl, string req);
    logic ld;
    @(negedge clk);
    bus_cs = cs; bus_rs = rs; bus_rd = rd; bus_wr = wr; bus_wdata = d;
    core_rx_valid = rxv; core_rx_code = rxc; core_flags = fl;
    @(negedge clk);
    bus_cs = 0; bus_rd = 0; bus_wr = 0; core_rx_valid = 0;
    ld = cs && wr && !rs;
    if (cs && rd) m_rd = rs ? exp_status(fl, m_pend) : m_rx;
    if (ld) m_tx = d;
    if (cs && wr && rs) begin
      if (m_arm) begin m_b = d; m_arm = 0; end
      else begin m_a = d; m_arm = d[3]; end
    end
    if (rxv) begin m_rx = rxc; m_pend = 1; end
    else if (cs && rd && !rs) m_pend = 0;
    chk_all(req, ld);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst = 1; bus_cs = 0; bus_rs = 0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    core_rx_code = '0; core_rx_valid = 0; core_flags = '0;
    m_a = 0; m_b = 0; m_tx = 0; m_rx = 0; m_rd = 0; m_arm = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    chk_all("R1 in reset", 1'b0);
    rst = 0;
    @(negedge clk);
    chk_all("R1 after reset", 1'b0);

    // R3 / R4: arm then redirect, then back to A
    access(1,1,0,1,4'h9,0,0,0,"R3 arm write A");
    access(1,1,0,1,4'h5,0,0,0,"R4 redirected to B");
    access(1,1,0,1,4'h3,0,0,0,"R4 back to A");
    // R5: b3 clear does not arm
    access(1,1,0,1,4'h7,0,0,0,"R5 no arm A");
    access(1,1,0,1,4'h2,0,0,0,"R5 still A");
    // R2 / R6: armed state survives data writes and deselected strobes (R10)
    access(1,1,0,1,4'hC,0,0,0,"R3 arm again");
    access(1,0,0,1,4'hE,0,0,0,"R2 tx write while armed");
    access(0,1,0,1,4'h1,0,0,0,"R10 deselected ctl write");
    access(1,1,0,1,4'h6,0,0,0,"R6 B after tx write");
    // R7 / R8 / R9
    access(0,0,0,0,0,1,4'hB,3'b101,"R7 digit in");
    access(1,1,1,0,0,0,0,3'b101,"R8 status pending");
    access(1,0,1,0,0,0,0,3'b000,"R7 read digit");
    access(1,1,1,0,0,0,0,3'b010,"R9 status cleared");
    access(0,0,0,0,0,1,4'h4,3'b000,"R7 digit in 2");
    access(1,0,1,0,0,1,4'hD,3'b000,"R9 read with new digit");
    access(1,1,1,0,0,0,0,3'b111,"R9 set wins");
    access(0,0,1,0,0,0,0,3'b011,"R10 deselected read");

    for (int i = 0; i < 400; i++) begin
      int k;
      logic [DW-1:0] d;
      logic [DW-2:0] f;
      k = int'($urandom_range(0, 5));
      d = DW'($urandom);
      f = (DW-1)'($urandom);
      case (k)
        0: access(1,0,0,1,d,0,0,f,"R2 rand tx");
        1: access(1,1,0,1,d,0,0,f,"R4 rand ctl");
        2: access(1,0,1,0,0,$urandom_range(0,1) == 1,DW'($urandom),f,"R9 rand rdrx");
        3: access(1,1,1,0,0,0,0,f,"R8 rand stat");
        4: access(0,0,0,0,0,1,d,f,"R7 rand digit");
        default: access(0,$urandom_range(0,1) == 1,1,1,d,0,0,f,"R10 rand desel");
      endcase
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule